// File: doc/BRIEF.md
# Video Front-End Reset and Output-Enable Sequencer

This block decides when a video front-end chip is held in reset and which of its output pins may drive. Three conditions start a reset: the chip-enable pin pulled low, an undervoltage flag on either supply, or a pixel clock that has stopped. A free-running reference clock watches the pixel clock, so a missing clock is still noticed when nothing else is ticking. The reset asserts asynchronously to the pixel domain, and it is released in step with the pixel clock.

Once the internal reset is released, a three-state machine runs through `S_RESET`, `S_STRETCH` and `S_RUN`. The indicator output stays low through the stretch phase, so other circuits on the board can use it as their own reset. The output pins fall into two groups. The clock, status, switch and data-line group drives again as soon as the internal reset releases. The sync and reference group stays tri-stated until a register bit is written to one. That bit is cleared by every reset.

The machine's transitions are as follows. `S_RESET` goes to `S_STRETCH` when the release reaches the final synchronizer stage. `S_STRETCH` goes to `S_RUN` after 128 pixel cycles. Any reset condition sends either state back to `S_RESET` asynchronously.

Top module: `vid_reset_seq`

## Requirements
- R1: If `chip_en` is low, or `dig_supply_low` or `ana_supply_low` is high, `core_rst_n` is low within 4 reference-clock cycles. `core_rst_n` stays low while any of these conditions lasts.
- R2: While `core_rst_n` is low, `auto_oe`, `sync_oe` and `rst_ind_n` are all 0.
- R3: After `core_rst_n` rises, `rst_ind_n` stays low for exactly 128 pixel-clock cycles. It then stays high until the next reset.
- R4: `auto_oe` is 1 from the pixel cycle in which `core_rst_n` rises.
- R5: After every reset, `sync_oe` is 0 until a write sets it.
- R6: Outside reset, a pixel cycle with `sync_wr`=1 loads `sync_val` into `sync_oe`. The new value is visible after that cycle's rising edge.
- R7: A write made while `core_rst_n` is low has no effect. `sync_oe` reads 0 after the release.
- R8: If the pixel clock halts for 40 reference cycles, `core_rst_n` is low by the end of that pause. The stretch sequence runs again once the clock resumes.
- R9: A pixel-clock pause of 5 reference cycles does not reset the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock used to watch the pixel clock |
| pix_clk | input | 1 | Line-locked pixel clock |
| chip_en | input | 1 | Chip enable, active high. Low forces reset |
| dig_supply_low | input | 1 | Digital supply undervoltage flag, active high |
| ana_supply_low | input | 1 | Analog supply undervoltage flag, active high |
| sync_wr | input | 1 | Write strobe for the sync-group enable bit (pixel domain) |
| sync_val | input | 1 | Value written to the sync-group enable bit |
| core_rst_n | output | 1 | Internal reset, active low |
| rst_ind_n | output | 1 | Stretched reset indicator for external circuits, active low |
| auto_oe | output | 1 | Drive enable for the clock, status, switch and data-line outputs |
| sync_oe | output | 1 | Drive enable for the sync and reference outputs |

## Verification
The hardest case to reach from the ports is clock loss. The stimulus has to stop the pixel clock itself, not raise a flag. Nothing then advances in the pixel domain, so the reset can only come from the reference-domain watchdog, asynchronously. The bench gates its own pixel-clock generator: it freezes the clock for 40 reference cycles, and for only 5 reference cycles to probe the short-pause side. It samples on reference-clock edges while the pixel clock is frozen. Random rounds mix clock stops with chip-enable and supply faults. Some rounds also issue writes during reset.

// File: rtl/vid_rst_pkg.sv
package vid_rst_pkg;
    typedef enum logic [1:0] {
        S_RESET   = 2'd0,
        S_STRETCH = 2'd1,
        S_RUN     = 2'd2
    } seq_state_t;
endpackage

// File: rtl/vid_clk_watch.sv
module vid_clk_watch #(
    parameter int LOSS_LIMIT = 16,
    parameter int STAGES     = 2
) (
    input  logic ref_clk,
    input  logic pix_clk,
    input  logic chip_en,
    output logic clk_lost
);
    localparam int CW = $clog2(LOSS_LIMIT + 1);

    logic          pix_tgl;
    logic [STAGES:0] tgl_q;
    logic [CW-1:0] gap_cnt;
    logic          edge_seen;

    always_ff @(posedge pix_clk or negedge chip_en) begin
        if (!chip_en) pix_tgl <= 1'b0;
        else          pix_tgl <= ~pix_tgl;
    end

    assign edge_seen = tgl_q[STAGES] ^ tgl_q[STAGES-1];

    always_ff @(posedge ref_clk or negedge chip_en) begin
        if (!chip_en) begin
            tgl_q   <= '0;
            gap_cnt <= '0;
        end else begin
            tgl_q <= {tgl_q[STAGES-1:0], pix_tgl};
            if (edge_seen)
                gap_cnt <= '0;
            else if (gap_cnt != CW'(LOSS_LIMIT))
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign clk_lost = (gap_cnt == CW'(LOSS_LIMIT));
endmodule

// File: rtl/vid_fault_sync.sv
module vid_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic chip_en,
    input  logic dig_supply_low,
    input  logic ana_supply_low,
    input  logic clk_lost,
    output logic fault_hold
);
    logic [STAGES-1:0] ce_q;
    logic [STAGES-1:0] uv_q;

    always_ff @(posedge ref_clk or negedge chip_en) begin
        if (!chip_en) begin
            ce_q       <= '0;
            uv_q       <= '1;
            fault_hold <= 1'b1;
        end else begin
            ce_q       <= {ce_q[STAGES-2:0], 1'b1};
            uv_q       <= {uv_q[STAGES-2:0], dig_supply_low | ana_supply_low};
            fault_hold <= ~ce_q[STAGES-1] | uv_q[STAGES-1] | clk_lost;
        end
    end
endmodule

// File: rtl/vid_rst_fsm.sv
module vid_rst_fsm
    import vid_rst_pkg::*;
#(
    parameter int STRETCH_LEN = 128,
    parameter int STAGES      = 2
) (
    input  logic pix_clk,
    input  logic fault_hold,
    input  logic sync_wr,
    input  logic sync_val,
    output logic core_rst_n,
    output logic rst_ind_n,
    output logic auto_oe,
    output logic sync_oe
);
    localparam int SW = (STRETCH_LEN > 1) ? $clog2(STRETCH_LEN) : 1;
    localparam logic [SW-1:0] LAST = SW'(STRETCH_LEN - 1);

    logic [STAGES-1:0] rel_q;
    logic              rel_early;
    seq_state_t        state, nxt;
    logic [SW-1:0]     str_cnt;
    logic              en_bit;

    always_ff @(posedge pix_clk or posedge fault_hold) begin
        if (fault_hold) rel_q <= '0;
        else            rel_q <= {rel_q[STAGES-2:0], 1'b1};
    end

    assign core_rst_n = rel_q[STAGES-1];
    assign rel_early  = rel_q[STAGES-2];

    always_ff @(posedge pix_clk or posedge fault_hold) begin
        if (fault_hold) state <= S_RESET;
        else            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RESET:   if (rel_early)        nxt = S_STRETCH;
            S_STRETCH: if (str_cnt == LAST)  nxt = S_RUN;
            S_RUN:                           nxt = S_RUN;
            default:                         nxt = S_RESET;
        endcase
    end

    always_ff @(posedge pix_clk or posedge fault_hold) begin
        if (fault_hold)              str_cnt <= '0;
        else if (state == S_STRETCH) str_cnt <= str_cnt + 1'b1;
        else                         str_cnt <= '0;
    end

    always_ff @(posedge pix_clk or posedge fault_hold) begin
        if (fault_hold)                        en_bit <= 1'b0;
        else if (sync_wr && state != S_RESET)  en_bit <= sync_val;
    end

    always_comb begin
        auto_oe   = (state != S_RESET);
        rst_ind_n = (state == S_RUN);
        sync_oe   = en_bit;
    end
endmodule

// File: rtl/vid_reset_seq.sv
module vid_reset_seq #(
    parameter int LOSS_LIMIT  = 16,
    parameter int STRETCH_LEN = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic pix_clk,
    input  logic chip_en,
    input  logic dig_supply_low,
    input  logic ana_supply_low,
    input  logic sync_wr,
    input  logic sync_val,
    output logic core_rst_n,
    output logic rst_ind_n,
    output logic auto_oe,
    output logic sync_oe
);
    logic clk_lost;
    logic fault_hold;

    vid_clk_watch #(.LOSS_LIMIT(LOSS_LIMIT), .STAGES(SYNC_STAGES)) u_watch (
        .ref_clk (ref_clk),
        .pix_clk (pix_clk),
        .chip_en (chip_en),
        .clk_lost(clk_lost)
    );

    vid_fault_sync #(.STAGES(SYNC_STAGES)) u_fault (
        .ref_clk       (ref_clk),
        .chip_en       (chip_en),
        .dig_supply_low(dig_supply_low),
        .ana_supply_low(ana_supply_low),
        .clk_lost      (clk_lost),
        .fault_hold    (fault_hold)
    );

    vid_rst_fsm #(.STRETCH_LEN(STRETCH_LEN), .STAGES(SYNC_STAGES)) u_fsm (
        .pix_clk   (pix_clk),
        .fault_hold(fault_hold),
        .sync_wr   (sync_wr),
        .sync_val  (sync_val),
        .core_rst_n(core_rst_n),
        .rst_ind_n (rst_ind_n),
        .auto_oe   (auto_oe),
        .sync_oe   (sync_oe)
    );
endmodule

// File: rtl/vid_reset_seq_chk.sv
module vid_reset_seq_chk (
    input logic ref_clk,
    input logic pix_clk,
    input logic chip_en,
    input logic clk_lost,
    input logic fault_hold,
    input logic sync_wr,
    input logic sync_val,
    input logic core_rst_n,
    input logic rst_ind_n,
    input logic auto_oe,
    input logic sync_oe
);
    always @(negedge pix_clk) begin
        if (core_rst_n === 1'b0)
            AST_OE_OFF_IN_RESET: assert (!auto_oe && !sync_oe && !rst_ind_n); // R2
        if (rst_ind_n === 1'b1)
            AST_IND_NEEDS_CORE: assert (core_rst_n); // R3
    end

    AST_LOSS_FORCES_HOLD: assert property (@(posedge ref_clk) disable iff (!chip_en)
        clk_lost |=> fault_hold); // R8

    AST_IND_STAYS_HIGH: assert property (@(posedge pix_clk) disable iff (fault_hold)
        rst_ind_n |=> rst_ind_n); // R3

    AST_SYNC_NEEDS_WRITE: assert property (@(posedge pix_clk) disable iff (fault_hold)
        $rose(sync_oe) |-> $past(sync_wr && sync_val)); // R6

    AST_AUTO_WITH_CORE: assert property (@(posedge pix_clk) disable iff (fault_hold)
        $rose(core_rst_n) |-> auto_oe); // R4
endmodule

bind vid_reset_seq vid_reset_seq_chk u_chk (
    .ref_clk   (ref_clk),
    .pix_clk   (pix_clk),
    .chip_en   (chip_en),
    .clk_lost  (clk_lost),
    .fault_hold(fault_hold),
    .sync_wr   (sync_wr),
    .sync_val  (sync_val),
    .core_rst_n(core_rst_n),
    .rst_ind_n (rst_ind_n),
    .auto_oe   (auto_oe),
    .sync_oe   (sync_oe)
);

// File: tb/vid_reset_seq_test.sv
`timescale 1ns/1ps
module vid_reset_seq_test;
    localparam int STRETCH = 128;

    logic ref_clk = 1'b0;
    logic pix_clk = 1'b0;
    logic pix_run = 1'b1;
    logic chip_en = 1'b0;
    logic dig_supply_low = 1'b0;
    logic ana_supply_low = 1'b0;
    logic sync_wr = 1'b0;
    logic sync_val = 1'b0;
    logic core_rst_n, rst_ind_n, auto_oe, sync_oe;

    int checks = 0;
    int fails  = 0;

    vid_reset_seq uut (
        .ref_clk(ref_clk), .pix_clk(pix_clk), .chip_en(chip_en),
        .dig_supply_low(dig_supply_low), .ana_supply_low(ana_supply_low),
        .sync_wr(sync_wr), .sync_val(sync_val),
        .core_rst_n(core_rst_n), .rst_ind_n(rst_ind_n),
        .auto_oe(auto_oe), .sync_oe(sync_oe)
    );

    always #2.5 ref_clk = ~ref_clk;
    always begin
        #7;
        if (pix_run) pix_clk = ~pix_clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic ref_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    function automatic int exp_stretch();
        return STRETCH;
    endfunction

    task automatic check_in_reset(input string req);
        chk({req, " core_rst_n"}, core_rst_n, 0);
        chk("R2 auto_oe", auto_oe, 0);
        chk("R2 sync_oe", sync_oe, 0);
        chk("R2 rst_ind_n", rst_ind_n, 0);
    endtask

    // wait for release, then measure the indicator stretch
    task automatic measure_release();
        int guard = 0;
        int lowcnt = 0;
        do begin
            @(negedge pix_clk);
            guard++;
        end while (!core_rst_n && guard < 200);
        chk("R4 auto_oe at release", auto_oe, 1);
        chk("R5 sync_oe after reset", sync_oe, 0);
        while (!rst_ind_n && lowcnt < 1000) begin
            lowcnt++;
            @(negedge pix_clk);
        end
        chk("R3 stretch length", lowcnt, exp_stretch());
        repeat (3) @(negedge pix_clk);
        chk("R3 indicator stays high", rst_ind_n, 1);
    endtask

    task automatic write_en(input logic v);
        @(negedge pix_clk);
        sync_wr = 1'b1;
        sync_val = v;
        @(negedge pix_clk);
        sync_wr = 1'b0;
        chk("R6 sync_oe after write", sync_oe, int'(v));
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        // reset state with chip enable low (R1, R2)
        ref_wait(10);
        check_in_reset("R1");
        chip_en = 1'b1;
        measure_release();
        write_en(1'b1);
        write_en(1'b0);
        write_en(1'b1);

        // R9: short pixel-clock pause must not reset
        @(negedge pix_clk);
        pix_run = 1'b0;
        ref_wait(5);
        pix_run = 1'b1;
        ref_wait(30);
        chk("R9 short pause no reset", core_rst_n, 1);
        chk("R9 sync_oe kept", sync_oe, 1);

        // R1: supply flag held after chip enable returns keeps reset
        dig_supply_low = 1'b1;
        ref_wait(4);
        check_in_reset("R1");
        chip_en = 1'b0;
        ref_wait(3);
        chip_en = 1'b1;
        ref_wait(20);
        chk("R1 flag still holds reset", core_rst_n, 0);
        dig_supply_low = 1'b0;
        measure_release();

        // random rounds
        for (int it = 0; it < 10; it++) begin
            int kind = $urandom_range(0, 3);
            int dur  = $urandom_range(10, 60);
            logic do_wr = 1'($urandom_range(0, 1));
            logic v = 1'($urandom_range(0, 1));
            unique case (kind)
                0: chip_en = 1'b0;
                1: dig_supply_low = 1'b1;
                2: ana_supply_low = 1'b1;
                default: pix_run = 1'b0;
            endcase
            if (kind == 3) begin
                ref_wait(40);
                chk("R8 clock loss resets", core_rst_n, 0);
                chk("R2 auto_oe in loss", auto_oe, 0);
                chk("R2 sync_oe in loss", sync_oe, 0);
            end else begin
                ref_wait(4);
                check_in_reset("R1");
            end
            if (do_wr) begin
                // R7: write during reset is ignored
                sync_wr = 1'b1;
                sync_val = 1'b1;
                ref_wait(8);
                sync_wr = 1'b0;
            end
            ref_wait(dur);
            chip_en = 1'b1;
            dig_supply_low = 1'b0;
            ana_supply_low = 1'b0;
            pix_run = 1'b1;
            measure_release();
            if (do_wr) chk("R7 reset-time write ignored", sync_oe, 0);
            write_en(v);
        end
        report();
    end
endmodule